// File: doc/BRIEF.md
# Banked Data-Memory Move Unit

This block carries out the data-movement instructions of a small 8-bit accumulator processor. It accepts one 16-bit instruction word at a time over a valid/ready handshake. It owns three pieces of state: a 4096-byte synchronous data store, the 8-bit working register W and a 4-bit bank register. Five kinds of instruction are supported. Load literal writes an immediate value into W. Load bank writes a value into the bank register. Store writes W into the data store. File move reads a location into W or writes it back onto itself. Copy moves a byte from one absolute location to another and is encoded in two words. Instruction fetch, arithmetic, branching and the call stack sit in other blocks.

Every single-word memory instruction carries an 8-bit location field and an access-select bit, and the 12-bit address is formed from these two. With the select bit set, the bank register supplies the upper four address bits. With the select bit clear, the bank register is bypassed. The lower half of the field then reaches the first 128 bytes of the store and the upper half reaches the last 128 bytes. This gives a program fast access to a shared window without reloading the bank.

The controller is a four-state machine:
- `ST_IDLE` accepts any instruction.
- `ST_SRC_HELD` holds a copy's source address while it waits for the copy's second word.
- `ST_FILE_RD` is the one stall cycle in which a file move's read data is used.
- `ST_COPY_WR` is the one stall cycle in which a copy's data is written.

The state machine has these transitions:
- `ST_IDLE` goes to `ST_FILE_RD` when it accepts a file move.
- `ST_IDLE` goes to `ST_SRC_HELD` when it accepts a copy's first word.
- `ST_SRC_HELD` goes to `ST_COPY_WR` when it accepts the next word.
- `ST_FILE_RD` goes back to `ST_IDLE` after one cycle.
- `ST_COPY_WR` goes back to `ST_IDLE` after one cycle.

Top module: `dmove_unit`

## Requirements
- R1: After reset, W reads 0, the bank register reads 0 and `in_ready` is high.
- R2: Word `0000_1110_kkkk_kkkk` loads the 8-bit k into W at the clock edge that accepts it.
- R3: Word `0000_0001_0000_kkkk` loads the 4-bit k into the bank register at the clock edge that accepts it.
- R4: A single-word memory instruction with access-select bit (bit 8) set addresses location {bank, field}, where the field is bits 7:0.
- R5: With bit 8 clear, a field value of 0x00–0x7F addresses 0x000–0x07F and a field value of 0x80–0xFF addresses 0xF80–0xFFF, whatever the bank register holds.
- R6: Word `0110_111a_ffff_ffff` writes W to the addressed location and leaves W unchanged.
- R7: Word `0101_00da_ffff_ffff` with d (bit 9) clear loads W from the addressed location. The new W value is visible one cycle after the cycle that follows acceptance.
- R8: The same word with d set writes the location's own value back to it and leaves W and the stored byte unchanged.
- R9: A first word `1100_ssss_ssss_ssss` followed by a second word `1111_dddd_dddd_dddd` copies the byte at absolute address s to absolute address d. The bank register is ignored, and W and the bank register are left unchanged.
- R10: A word with the `1111` prefix that arrives when no copy is pending has no effect on W, the bank register or the data store.
- R11: `in_ready` is low for exactly the one cycle after a file move or a copy's second word is accepted, and high at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 16 | Instruction word |
| in_ready | output | 1 | Unit can accept a word this cycle |
| w_value | output | 8 | Current working register |
| bank_value | output | 4 | Current bank register |

## Verification
The bench sweeps all 256 field values with access-select clear while the bank register holds a non-zero value. A design that added the bank into that path, or that mapped the upper half of the field into the bottom page, would return the wrong preset byte at the boundary fields 0x7F and 0x80. Banked reads cover all sixteen banks at the edge fields, and they catch a swapped or truncated bank concatenation. A copy is followed directly by a file move of its destination. That order exposes a design that accepted the next word before the copy's write landed, or that used the bank register for the copy. A stray `1111` word is sent, and a write-back move is checked to leave W intact. Either one would reveal a decoder that treated these words as stores or loads.

// File: rtl/dmove_pkg.sv
package dmove_pkg;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_LIT,
        OP_BANK,
        OP_STORE,
        OP_MOVF,
        OP_COPY_SRC
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SRC_HELD,
        ST_FILE_RD,
        ST_COPY_WR
    } state_e;

    typedef struct packed {
        op_e        op;
        logic       acc_bank;
        logic       to_file;
        logic [7:0] field;
    } dec_t;

endpackage

// File: rtl/dmove_decode.sv
module dmove_decode
    import dmove_pkg::*;
(
    input  logic [15:0] word,
    output dec_t        dec
);

    always_comb begin
        dec.acc_bank = word[8];
        dec.to_file  = word[9];
        dec.field    = word[7:0];
        casez (word)
            16'b0000_1110_????_????: dec.op = OP_LIT;
            16'b0000_0001_0000_????: dec.op = OP_BANK;
            16'b0110_111?_????_????: dec.op = OP_STORE;
            16'b0101_00??_????_????: dec.op = OP_MOVF;
            16'b1100_????_????_????: dec.op = OP_COPY_SRC;
            default:                 dec.op = OP_NOP;
        endcase
    end

endmodule

// File: rtl/dmove_addr.sv
module dmove_addr #(
    parameter int FIELD_W = 8,
    parameter int BANK_W  = 4,
    localparam int ADDR_W = FIELD_W + BANK_W
) (
    input  logic               acc_bank,
    input  logic [FIELD_W-1:0] field,
    input  logic [BANK_W-1:0]  bank,
    output logic [ADDR_W-1:0]  addr
);

    // Window select: lower half of field -> bottom page, upper half -> top page
    logic [BANK_W-1:0] page;

    always_comb begin
        if (acc_bank) begin
            page = bank;
        end else begin
            page = {BANK_W{field[FIELD_W-1]}};
        end
        addr = {page, field};
    end

    // R5: unbanked accesses only ever reach the first or last page
    always_comb begin
        if (!acc_bank && !$isunknown(field)) begin
            assert_access_page_R5: assert (addr[ADDR_W-1:FIELD_W] == '0 ||
                                           addr[ADDR_W-1:FIELD_W] == '1);
        end
    end

endmodule

// File: rtl/dmove_ram.sv
module dmove_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 12,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                store[addr] <= wdata;
            end
            rdata <= store[addr];
        end
    end

endmodule

// File: rtl/dmove_unit.sv
module dmove_unit
    import dmove_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FIELD_W = 8,
    parameter int BANK_W  = 4,
    localparam int ADDR_W = FIELD_W + BANK_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] in_word,
    output logic        in_ready,
    output logic [7:0]  w_value,
    output logic [3:0]  bank_value
);

    state_e              st_q, st_d;
    dec_t                dec;
    logic [ADDR_W-1:0]   eff_addr;
    logic [ADDR_W-1:0]   src_q;
    logic [ADDR_W-1:0]   hold_addr_q;
    logic                hold_wb_q;
    logic [DATA_W-1:0]   w_q;
    logic [BANK_W-1:0]   bank_q;
    logic                take;
    logic                mem_en, mem_we;
    logic [ADDR_W-1:0]   mem_addr;
    logic [DATA_W-1:0]   mem_wdata, mem_rdata;

    dmove_decode u_dec (
        .word (in_word),
        .dec  (dec)
    );

    dmove_addr #(.FIELD_W(FIELD_W), .BANK_W(BANK_W)) u_addr (
        .acc_bank (dec.acc_bank),
        .field    (dec.field),
        .bank     (bank_q),
        .addr     (eff_addr)
    );

    dmove_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign take       = in_valid && in_ready;
    assign w_value    = w_q;
    assign bank_value = bank_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (take && dec.op == OP_MOVF)     st_d = ST_FILE_RD;
                if (take && dec.op == OP_COPY_SRC) st_d = ST_SRC_HELD;
            end
            ST_SRC_HELD: if (take) st_d = ST_COPY_WR;
            ST_FILE_RD:  st_d = ST_IDLE;
            ST_COPY_WR:  st_d = ST_IDLE;
        endcase
    end

    // Outputs and memory port
    always_comb begin
        in_ready  = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = eff_addr;
        mem_wdata = w_q;
        unique case (st_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (take && dec.op == OP_STORE) begin
                    mem_en = 1'b1;
                    mem_we = 1'b1;
                end
                if (take && dec.op == OP_MOVF) begin
                    mem_en = 1'b1;
                end
            end
            ST_SRC_HELD: begin
                in_ready = 1'b1;
                mem_addr = src_q;
                mem_en   = take;
            end
            ST_FILE_RD: begin
                mem_addr  = hold_addr_q;
                mem_wdata = mem_rdata;
                mem_en    = hold_wb_q;
                mem_we    = hold_wb_q;
            end
            ST_COPY_WR: begin
                mem_addr  = hold_addr_q;
                mem_wdata = mem_rdata;
                mem_en    = 1'b1;
                mem_we    = 1'b1;
            end
        endcase
    end

    // Architectural and holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q         <= '0;
            bank_q      <= '0;
            src_q       <= '0;
            hold_addr_q <= '0;
            hold_wb_q   <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (take) begin
                        unique case (dec.op)
                            OP_LIT:      w_q    <= in_word[DATA_W-1:0];
                            OP_BANK:     bank_q <= in_word[BANK_W-1:0];
                            OP_MOVF: begin
                                hold_addr_q <= eff_addr;
                                hold_wb_q   <= dec.to_file;
                            end
                            OP_COPY_SRC: src_q <= in_word[ADDR_W-1:0];
                            default: ;
                        endcase
                    end
                end
                ST_SRC_HELD: if (take) hold_addr_q <= in_word[ADDR_W-1:0];
                ST_FILE_RD:  if (!hold_wb_q) w_q <= mem_rdata;
                ST_COPY_WR:  ;
            endcase
        end
    end

    // R11: a stall lasts one cycle only
    assert_stall_short_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    // R7: a file move stalls the port on the next cycle
    assert_movf_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q == ST_IDLE && dec.op == OP_MOVF) |=> !in_ready);

    // R9: the copy's second word stalls the port on the next cycle
    assert_copy_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q == ST_SRC_HELD) |=> !in_ready);

    // R6: storing W does not alter W
    assert_store_keeps_w_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q == ST_IDLE && dec.op == OP_STORE) |=> $stable(w_value));

    // R2: literal lands in W
    assert_lit_to_w_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q == ST_IDLE && dec.op == OP_LIT) |=> w_value == $past(in_word[7:0]));

    // R3: literal lands in bank register
    assert_lit_to_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q == ST_IDLE && dec.op == OP_BANK) |=> bank_value == $past(in_word[3:0]));

    // R10: stray second-word prefix changes nothing visible
    assert_stray_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q == ST_IDLE && in_word[15:12] == 4'hF) |=>
            ($stable(w_value) && $stable(bank_value)));

endmodule

// File: tb/dmove_unit_bench.sv
module dmove_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_ready;
    logic [7:0]  w_value;
    logic [3:0]  bank_value;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [4096];

    always #10 clk = ~clk;

    dmove_unit u_dmove_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .in_ready   (in_ready),
        .w_value    (w_value),
        .bank_value (bank_value)
    );

    function automatic logic [7:0] initv(input int a);
        return 8'((a * 37) + ((a >> 4) * 11) + 8'h5A);
    endfunction

    function automatic logic [11:0] unbanked(input logic [7:0] f);
        if (f < 8'h80) return {4'h0, f};
        return 12'hF00 + 12'(f);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Returns just after the clock edge that accepted the word
    task automatic send(input logic [15:0] wd);
        bit ok;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = wd;
        do begin
            ok = in_ready;
            @(posedge clk);
            #1;
        end while (!ok);
        in_valid = 1'b0;
    endtask

    task automatic rd_abs(input logic [11:0] a, output logic [7:0] v);
        send({12'h010, a[11:8]});
        send({8'h51, a[7:0]});
        idle(2);
        v = w_value;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [11:0] a;
        logic [11:0] srcs [4];
        logic [11:0] dsts [4];
        logic [7:0]  edges [5];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        chk("R1 w after reset", w_value, 0);
        chk("R1 bank after reset", bank_value, 0);
        chk("R1 ready after reset", in_ready, 1);

        // R2 literal sweep
        for (int k = 0; k < 256; k++) begin
            send({8'h0E, 8'(k)});
            chk("R2 literal to W", w_value, k);
        end
        // R3 bank sweep
        for (int k = 0; k < 16; k++) begin
            send({12'h010, 4'(k)});
            chk("R3 bank load", bank_value, k);
        end

        // Preset the whole store through banked stores (R4, R6)
        for (int b = 0; b < 16; b++) begin
            send({12'h010, 4'(b)});
            for (int f = 0; f < 256; f++) begin
                a = 12'((b << 8) | f);
                send({8'h0E, initv(int'(a))});
                send({8'h6F, 8'(f)});
                ref_mem[a] = initv(int'(a));
            end
        end

        // R5 unbanked read sweep with a non-zero bank
        send(16'h0109);
        for (int f = 0; f < 256; f++) begin
            send({8'h50, 8'(f)});
            chk("R11 ready low after file move", in_ready, 0);
            idle(2);
            chk("R5 unbanked read", w_value, ref_mem[unbanked(8'(f))]);
            chk("R11 ready back high", in_ready, 1);
        end

        // R4 banked read at edge fields for every bank
        edges = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h00};
        for (int b = 0; b < 16; b++) begin
            edges[4] = 8'(b * 13);
            for (int e = 0; e < 5; e++) begin
                send({12'h010, 4'(b)});
                send({8'h51, edges[e]});
                idle(2);
                chk("R4 banked read", w_value, ref_mem[{4'(b), edges[e]}]);
            end
        end

        // R6 unbanked store with bank 3, W unchanged
        send(16'h0103);
        edges = '{8'h10, 8'h90, 8'h7F, 8'h80, 8'hC3};
        for (int e = 0; e < 5; e++) begin
            v = 8'(8'hA0 + e * 7);
            send({8'h0E, v});
            send({8'h6E, edges[e]});
            idle(1);
            chk("R6 W unchanged by store", w_value, v);
            ref_mem[unbanked(edges[e])] = v;
            rd_abs(unbanked(edges[e]), v);
            chk("R6 stored byte at unbanked addr", v, ref_mem[unbanked(edges[e])]);
            rd_abs({4'h3, edges[e]}, v);
            chk("R5 bank 3 location untouched", v, ref_mem[{4'h3, edges[e]}]);
            send(16'h0103);
        end

        // R8 write-back move keeps W and byte
        send(16'h010A);
        send(16'h0E11);
        send(16'h5333);
        idle(2);
        chk("R8 W unchanged by write-back", w_value, 8'h11);
        rd_abs(12'hA33, v);
        chk("R8 byte unchanged by write-back", v, ref_mem[12'hA33]);
        send(16'h0E22);
        send(16'h5245);
        idle(2);
        chk("R8 unbanked write-back W", w_value, 8'h22);

        // R9 copies, bank set to destination bank, read back-to-back
        srcs = '{12'h1A0, 12'h07F, 12'hF80, 12'h555};
        dsts = '{12'h23F, 12'hE01, 12'h000, 12'hFFF};
        for (int i = 0; i < 4; i++) begin
            send({12'h010, dsts[i][11:8]});
            send(16'h0E5C);
            send({4'hC, srcs[i]});
            chk("R9 ready held while copy pending", in_ready, 1);
            chk("R9 W stable while pending", w_value, 8'h5C);
            send({4'hF, dsts[i]});
            chk("R11 ready low after copy word", in_ready, 0);
            ref_mem[dsts[i]] = ref_mem[srcs[i]];
            send({8'h51, dsts[i][7:0]});
            idle(2);
            chk("R9 copied byte", w_value, ref_mem[srcs[i]]);
            chk("R9 bank untouched", bank_value, dsts[i][11:8]);
        end
        rd_abs(12'h1A0, v);
        chk("R9 source unchanged", v, ref_mem[12'h1A0]);

        // R10 stray second word
        send(16'h0104);
        send(16'h0E77);
        send(16'hF123);
        idle(2);
        chk("R10 W after stray", w_value, 8'h77);
        chk("R10 bank after stray", bank_value, 4);
        chk("R10 ready after stray", in_ready, 1);
        rd_abs(12'h123, v);
        chk("R10 memory after stray", v, ref_mem[12'h123]);
        rd_abs(12'h077, v);
        chk("R10 W-valued address untouched", v, ref_mem[12'h077]);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule